// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches a single 16-bit word from a serial EEPROM that talks over chip select, a serial clock, a data line into the memory and a data line out of it. A requester presents a 6-bit word address with a one-cycle request. The block then runs the whole read transaction on the wire on its own and returns the word together with a one-cycle done pulse.

The serial clock is slow compared with the system clock. Every level on the wire lasts `HALF_PERIOD` system cycles. A default of 8000 gives about 40 microseconds per level at 200 MHz. A transaction is built from 54 such half-periods, in this order:
- one select half-period with the clock low;
- 25 bit slots, each made of a low half and a high half;
- one low half that still has the device selected;
- a trailing high half and then a low half, both with the device deselected.

Top module: `mw_eeprom_rd`

## Requirements
- R1: The frame shifted to the memory is 9 bits, most significant bit first: the read code 1,1,0 followed by the 6 address bits. One bit is sent per serial clock pulse, and the memory captures each bit on the rising clock edge.
- R2: Chip select goes high one half-period before any clock activity. It stays high through all 25 bit slots and the low half after them, and it is low while idle.
- R3: Every serial clock level lasts `HALF_PERIOD` system cycles. There are 25 clock pulses with chip select high, followed by exactly one trailing pulse with chip select low.
- R4: The data line to the memory holds each command bit through both the low half and the high half of that bit's slot, so it never changes at a rising clock edge.
- R5: The data line to the memory is low whenever chip select is low, and also throughout the 16 data slots.
- R6: The 16 reply bits are sampled from the memory's output in the last system cycle of each high half and assembled most significant bit first. The word appears on `data_o` in the done cycle and is held until the next done.
- R7: `busy_o` is high from the cycle after an accepted request until the done cycle. A request that arrives while busy is ignored and does not change the address or the result.
- R8: While reset is asserted, and right after it, all outputs are low, including `data_o`.
- R9: `done_o` is a one-cycle pulse that comes exactly 54 × `HALF_PERIOD` cycles after the clock edge that accepted the request.
- R10: While idle, the serial clock is low. A request held high is accepted again in the cycle right after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a read; sampled only when not busy |
| addr_i | input | 6 | Word address, captured with the request |
| eep_do_i | input | 1 | Serial data from the memory |
| eep_cs_o | output | 1 | Chip select to the memory |
| eep_sk_o | output | 1 | Serial clock to the memory |
| eep_di_o | output | 1 | Serial data to the memory |
| busy_o | output | 1 | Read in progress |
| done_o | output | 1 | One-cycle pulse: word is valid |
| data_o | output | 16 | Last word read |

## Verification
A behavioural memory model in the bench answers only to the wire activity it sees. Reads are run at the lowest and highest addresses and at two alternating-bit addresses. These tell apart faults in command-bit order, in the address slice and in the reply shift direction. The stored words include all-zero, all-one and alternating patterns, so a stuck or shifted sampling slot shows up in the returned value. Further cases cover a request pulsed mid-transaction, a request held high across two reads, and a reset in the middle of a read; these separate correct ignore, re-accept and abort behaviour from their look-alikes.

// File: rtl/mw_rd_pkg.sv
package mw_rd_pkg;
  localparam logic [2:0] RD_OPCODE = 3'b110;
  localparam int unsigned OP_W = 3;

  // select + 2 per bit + post-data low + trailing high + trailing low, minus one
  function automatic int unsigned last_phase(input int unsigned aw, input int unsigned dw);
    return 2 * (OP_W + aw + dw) + 3;
  endfunction
endpackage

// File: rtl/mw_half_tick.sv
module mw_half_tick #(
  parameter int unsigned HALF_PERIOD = 8000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_PERIOD < 2) ? 1 : $clog2(HALF_PERIOD);
  localparam logic [CW-1:0] TOP = CW'(HALF_PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!run_i || cnt_q == TOP) cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == TOP);
endmodule

// File: rtl/mw_rd_seq.sv
module mw_rd_seq
  import mw_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              cs_o,
  output logic              sk_o,
  output logic              di_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned CMD_W    = OP_W + ADDR_W;
  localparam int unsigned CMD_END  = 2 * CMD_W;
  localparam int unsigned DATA_END = 2 * (CMD_W + DATA_W);
  localparam int unsigned LAST     = last_phase(ADDR_W, DATA_W);
  localparam int unsigned PW       = $clog2(LAST + 1);

  logic [PW-1:0]     phase_q;
  logic              busy_q, done_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] rx_q, data_q;
  logic              hi_half;

  // even phases 2..DATA_END are the high half of a bit slot
  assign hi_half = !phase_q[0] && (phase_q != '0) && (phase_q <= PW'(DATA_END));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cmd_q   <= '0;
      rx_q    <= '0;
      data_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (req_i) begin
          busy_q  <= 1'b1;
          phase_q <= '0;
          cmd_q   <= {RD_OPCODE, addr_i};
        end
      end else if (tick_i) begin
        if (phase_q == PW'(LAST)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          data_q <= rx_q;
        end else begin
          phase_q <= phase_q + 1'b1;
        end
        if (hi_half && phase_q <= PW'(CMD_END)) cmd_q <= {cmd_q[CMD_W-2:0], 1'b0};
        if (hi_half && phase_q >  PW'(CMD_END)) rx_q  <= {rx_q[DATA_W-2:0], miso_i};
      end
    end
  end

  assign cs_o   = busy_q && (phase_q <= PW'(DATA_END + 1));
  assign sk_o   = busy_q && (hi_half || phase_q == PW'(DATA_END + 2));
  assign di_o   = busy_q && (phase_q != '0) && (phase_q <= PW'(CMD_END)) && cmd_q[CMD_W-1];
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign data_o = data_q;
endmodule

// File: rtl/mw_eeprom_rd.sv
module mw_eeprom_rd #(
  parameter int unsigned HALF_PERIOD = 8000,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned DATA_W      = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              eep_do_i,
  output logic              eep_cs_o,
  output logic              eep_sk_o,
  output logic              eep_di_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o
);
  logic tick;
  logic busy;

  mw_half_tick #(.HALF_PERIOD(HALF_PERIOD)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .tick_o (tick)
  );

  mw_rd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .addr_i (addr_i),
    .tick_i (tick),
    .miso_i (eep_do_i),
    .cs_o   (eep_cs_o),
    .sk_o   (eep_sk_o),
    .di_o   (eep_di_o),
    .busy_o (busy),
    .done_o (done_o),
    .data_o (data_o)
  );

  assign busy_o = busy;
endmodule

// File: rtl/mw_eeprom_rd_chk.sv
module mw_eeprom_rd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic eep_cs_o,
  input logic eep_sk_o,
  input logic eep_di_o,
  input logic busy_o,
  input logic done_o
);
  p_di_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eep_cs_o |-> !eep_di_o);

  p_cs_ahead_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eep_cs_o) |-> !eep_sk_o);

  p_di_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eep_cs_o && $rose(eep_sk_o)) |-> $stable(eep_di_o));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_ends_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  p_req_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_i) |=> (busy_o || done_o));

  p_done_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!eep_sk_o && !eep_cs_o));
endmodule

bind mw_eeprom_rd mw_eeprom_rd_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .eep_cs_o (eep_cs_o),
  .eep_sk_o (eep_sk_o),
  .eep_di_o (eep_di_o),
  .busy_o   (busy_o),
  .done_o   (done_o)
);

// File: tb/tb_mw_eeprom_rd.sv
`timescale 1ns/1ps
module tb_mw_eeprom_rd;
  localparam int H   = 3;
  localparam int TOT = 54 * H;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic        eep_do_i = 1'b0;
  logic        eep_cs_o, eep_sk_o, eep_di_o, busy_o, done_o;
  logic [15:0] data_o;

  always #2.5 clk = ~clk;

  mw_eeprom_rd #(.HALF_PERIOD(H)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
    .eep_do_i(eep_do_i), .eep_cs_o(eep_cs_o), .eep_sk_o(eep_sk_o),
    .eep_di_o(eep_di_o), .busy_o(busy_o), .done_o(done_o), .data_o(data_o)
  );

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0;
  logic [15:0] mem [64];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // reference model: cycles since accepting edge
  bit        m_active = 0;
  int        m_t = 0;
  logic [5:0] m_addr = '0;
  logic [15:0] m_last = '0;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_active = 0; m_t = 0; m_last = '0;
    end else begin
      bit pre_busy;
      pre_busy = m_active && (m_t < TOT);
      if (req_i && !pre_busy) begin
        m_active = 1; m_t = 0; m_addr = addr_i;
      end else if (m_active) begin
        m_t++;
        if (m_t > TOT) m_active = 0;
      end
    end
  end

  // compare every cycle
  always @(negedge clk) begin
    int p;
    bit e_cs, e_sk, e_di, e_busy, e_done;
    logic [8:0] cmd;
    e_cs = 0; e_sk = 0; e_di = 0; e_busy = 0; e_done = 0;
    cmd = {3'b110, m_addr};
    if (m_active && m_t < TOT) begin
      p = m_t / H;
      e_busy = 1;
      e_cs = (p <= 51);
      e_sk = (p >= 2 && p <= 50 && p % 2 == 0) || p == 52;
      e_di = (p >= 1 && p <= 18) ? cmd[8 - (p - 1) / 2] : 1'b0;
    end else if (m_active && m_t == TOT) begin
      e_done = 1;
      m_last = mem[m_addr];
    end
    chk(eep_cs_o == e_cs, "R2 cs", eep_cs_o, e_cs);
    chk(eep_sk_o == e_sk, "R3 sk", eep_sk_o, e_sk);
    chk(eep_di_o == e_di, e_cs ? "R4 di" : "R5 di", eep_di_o, e_di);
    chk(busy_o == e_busy, "R7 busy", busy_o, e_busy);
    chk(done_o == e_done, "R9 done", done_o, e_done);
    chk(data_o == m_last, "R6 data", data_o, m_last);
  end

  // memory slave driven only from wire activity
  bit        s_sk = 0;
  int        s_rc = 0, s_fc = 0;
  logic [8:0] s_cmd = '0;
  always @(negedge clk) begin
    if (!eep_cs_o) begin
      s_rc = 0; s_fc = 0; eep_do_i = 1'b0;
    end else if (eep_sk_o && !s_sk) begin
      if (s_rc < 9) begin
        s_cmd = {s_cmd[7:0], eep_di_o};
        s_rc++;
        if (s_rc == 9)
          chk(s_cmd == {3'b110, m_addr}, "R1 frame", s_cmd, {3'b110, m_addr});
      end
    end else if (!eep_sk_o && s_sk) begin
      s_fc++;
      if (s_fc >= 9 && s_fc < 25) eep_do_i = mem[s_cmd[5:0]][15 - (s_fc - 9)];
      else eep_do_i = 1'b0;
    end
    s_sk = eep_sk_o;
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      finish_run();
    end
  end

  task automatic at_drive();
    @(negedge clk); #1;
  endtask

  task automatic do_read(input logic [5:0] a);
    at_drive(); req_i = 1'b1; addr_i = a;
    at_drive(); req_i = 1'b0; addr_i = ~a;
    repeat (TOT + 4) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'((i * 16'h1F3B) ^ 16'h5AC3);
    mem[0] = 16'h0000; mem[63] = 16'hFFFF; mem[42] = 16'hAAAA; mem[21] = 16'h5555;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk({eep_cs_o, eep_sk_o, eep_di_o, busy_o, done_o} == 5'b0, "R8 outs", 0, 0);
    chk(data_o == 16'h0, "R8 data", data_o, 0);
    at_drive(); rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    // R1 R6: address and data patterns
    do_read(6'd0);
    do_read(6'd63);
    do_read(6'd42);
    do_read(6'd21);
    do_read(6'd13);
    // R7: request mid-read is ignored
    at_drive(); req_i = 1'b1; addr_i = 6'd9;
    at_drive(); req_i = 1'b0;
    repeat (40) @(negedge clk);
    at_drive(); req_i = 1'b1; addr_i = 6'd50;
    at_drive(); req_i = 1'b0;
    repeat (TOT) @(negedge clk);
    chk(data_o == mem[9], "R7 ignore", data_o, mem[9]);
    // R10: held request re-accepted right after done
    at_drive(); req_i = 1'b1; addr_i = 6'd33;
    repeat (2 * TOT + 1) @(negedge clk);
    at_drive(); req_i = 1'b0;
    repeat (TOT + 4) @(negedge clk);
    // R8: reset in mid-read aborts
    at_drive(); req_i = 1'b1; addr_i = 6'd5;
    at_drive(); req_i = 1'b0;
    repeat (70) @(negedge clk);
    at_drive(); rst_ni = 1'b0;
    @(negedge clk);
    chk({eep_cs_o, eep_sk_o, busy_o} == 3'b0, "R8 abort", {eep_cs_o, eep_sk_o, busy_o}, 0);
    at_drive(); rst_ni = 1'b1;
    do_read(6'd5);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule